// File: doc/BRIEF.md
# Receive FIFO with Four-Byte Quantized Almost-Full Interrupt

This block buffers received payload bytes between a demodulator, which pushes one byte per cycle through the write port, and a host, which pops bytes through a show-ahead read port. Alongside the usual occupancy outputs (full, empty, byte count) it raises an almost-full interrupt so that the host can start draining before the buffer overflows.

The interrupt threshold is programmed in bytes, but the comparison is made only on whole groups of four bytes. The programmed value is rounded up to the next multiple of four, and the interrupt latches on the write that brings the occupancy to exactly that rounded level. Programming 1, 2, 3 or 4 therefore trips on the fourth stored byte, and 5 to 8 trips on the eighth. The latch holds until the host acknowledges it. A write that arrives while the buffer is full is discarded, and a sticky overflow flag records the loss.

Top module: `rxq_fifo_top`

## Requirements
- R1: After reset, empty is 1, full is 0, count is 0, af_irq is 0 and ovf is 0.
- R2: Bytes leave in the order they were written. While empty is 0, rd_data shows the oldest stored byte, and a read removes it.
- R3: count equals the number of stored bytes (0 to 64). full is 1 exactly when count is 64, and empty is 1 exactly when count is 0.
- R4: A write while full, with no read in the same cycle, is discarded: count and the stored bytes are unchanged. ovf goes to 1 on the next cycle and stays 1 until a cycle with ovf_clr high.
- R5: A read while empty is ignored: count stays 0 and empty stays 1.
- R6: The trip level is thr rounded up to a multiple of four, computed as ((thr + 3) >> 2) << 2. af_irq goes to 1 in the same cycle that count first shows the trip level, after a write-only cycle that raised count from trip-1 to trip. Writes that pass the level later do not trip again, but refilling to the level after a drain trips again.
- R7: A thr of 0 disables the interrupt: af_irq never sets.
- R8: af_irq stays 1 until a cycle with af_ack high clears it. If a tripping write and af_ack occur in the same cycle, af_irq ends up set.
- R9: A cycle with both a successful read and a write leaves count unchanged and never sets af_irq, even at trip-1.
- R10: A trip level above 64 (thr of 65 or more) is never reached, so af_irq stays 0. A trip level of exactly 64 sets af_irq on the write that fills the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Demodulator byte write request |
| wr_data | input | 8 | Byte to store |
| full | output | 1 | Buffer holds 64 bytes |
| ovf | output | 1 | Sticky flag: a write was dropped while full |
| ovf_clr | input | 1 | Clears ovf |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| empty | output | 1 | Buffer holds no bytes |
| count | output | 7 | Number of stored bytes |
| thr | input | 7 | Programmed almost-full threshold in bytes; 0 disables |
| af_irq | output | 1 | Sticky almost-full interrupt |
| af_ack | input | 1 | Host acknowledge, clears af_irq |

## Verification
The rounding is tried with thresholds at both ends of a four-byte group (1, 3, 4, 5, 8, 9, 13), so that exact comparison, round-down and round-up each give a distinguishable trip byte. Fills with thresholds of 0, 62 and 65 separate a disabled flag, a trip level equal to the depth and an unreachable one. Mixed read-and-write cycles at trip-1, and an acknowledge in the same cycle as a tripping write, check the count-neutral and priority cases. A fill past full, followed by a complete drain, shows whether the dropped byte was kept and whether byte order survives wrap-around.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Effective operation of the buffer in one cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_BOTH = 2'b11
   } rxq_op_e;

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_mem: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] cells_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells_q[waddr] <= wdata;
      end
   end

   // Show-ahead read port
   assign rdata = cells_q[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             ovf_clr,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty,
   output logic             ovf,
   output rxq_op_e          op
);

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("rxq_ctrl: DEPTH must be a power of two, at least 2");
   end

   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             rd_fire, wr_fire, wr_drop;

   assign full  = (count_q == FULL_LVL);
   assign empty = (count_q == '0);

   assign rd_fire = rd_en && !empty;
   // A pop in the same cycle frees a slot, so a write to a full buffer is accepted then
   assign wr_fire = wr_en && (!full || rd_fire);
   assign wr_drop = wr_en && !wr_fire;

   always_comb begin
      unique case ({rd_fire, wr_fire})
         2'b01:   op = OP_PUSH;
         2'b10:   op = OP_POP;
         2'b11:   op = OP_BOTH;
         default: op = OP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (wr_fire) begin
            wr_ptr_q <= wr_ptr_q + AW'(1);
         end
         if (rd_fire) begin
            rd_ptr_q <= rd_ptr_q + AW'(1);
         end
         case (op)
            OP_PUSH: count_q <= count_q + CNT_W'(1);
            OP_POP:  count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   // Overflow latch: a dropped write wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wr_drop) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end

   assign wr_ptr = wr_ptr_q;
   assign rd_ptr = rd_ptr_q;
   assign count  = count_q;
   assign ovf    = ovf_q;

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_LVL);

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> ($stable(count_q) && ovf_q));

   assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> (count_q == '0));

   assert_both_neutral_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && !empty) |=> $stable(count_q));

   assert_ptr_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != FULL_LVL) |-> (AW'(wr_ptr_q - rd_ptr_q) == count_q[AW-1:0]));

endmodule

// File: rtl/rxq_trip.sv
module rxq_trip
   import rxq_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int GRAN  = 4,
   parameter int DEPTH = 64,
   localparam int GL   = $clog2(GRAN),
   localparam int TW   = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rxq_op_e          op,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thr,
   input  logic             ack,
   output logic             irq
);

   if ((GRAN < 1) || ((GRAN & (GRAN - 1)) != 0) || (GRAN > DEPTH)) begin : g_bad_gran
      $error("rxq_trip: GRAN must be a power of two no larger than DEPTH");
   end

   logic [TW-1:0] trip_lvl;
   logic [TW-1:0] cnt_plus1;
   logic          hit;
   logic          irq_q;

   if (GRAN == 1) begin : g_exact
      assign trip_lvl = {1'b0, thr};
   end else begin : g_quant
      logic [TW-1:0] padded;
      assign padded   = {1'b0, thr} + TW'(GRAN - 1);
      assign trip_lvl = {padded[TW-1:GL], {GL{1'b0}}};
   end

   assign cnt_plus1 = {1'b0, count} + TW'(1);

   // Only a write-only cycle that lands exactly on the level trips the latch
   assign hit = (op == OP_PUSH) && (thr != '0) && (cnt_plus1 == trip_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (hit) begin
         irq_q <= 1'b1;
      end else if (ack) begin
         irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   assert_rise_at_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> (({1'b0, count} == trip_lvl) && (count[GL-1+((GL==0)?1:0):0] == '0 || GL == 0)));

   assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr == '0) && !irq_q) |=> !irq_q);

   assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (op != OP_PUSH)) |=> !irq_q);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack) |=> irq_q);

   assert_both_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_BOTH) && !irq_q) |=> !irq_q);

endmodule

// File: rtl/rxq_fifo_top.sv
module rxq_fifo_top
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int GRAN   = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   output logic              ovf,
   input  logic              ovf_clr,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  thr,
   output logic              af_irq,
   input  logic              af_ack
);

   logic [AW-1:0] wr_ptr, rd_ptr;
   rxq_op_e       op;
   logic          push_en;

   assign push_en = (op == OP_PUSH) || (op == OP_BOTH);

   rxq_ctrl #(
      .DEPTH (DEPTH)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .ovf_clr (ovf_clr),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .count   (count),
      .full    (full),
      .empty   (empty),
      .ovf     (ovf),
      .op      (op)
   );

   rxq_mem #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) mem_i (
      .clk   (clk),
      .we    (push_en),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (rd_data)
   );

   rxq_trip #(
      .CNT_W (CNT_W),
      .GRAN  (GRAN),
      .DEPTH (DEPTH)
   ) trip_i (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .count (count),
      .thr   (thr),
      .ack   (af_ack),
      .irq   (af_irq)
   );

   assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_ovf_from_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(full));

endmodule

// File: tb/rxq_fifo_top_tb_top.sv
module rxq_fifo_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, rd_en, ovf_clr, af_ack;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       full, empty, ovf, af_irq;
   logic [6:0] count;
   logic [6:0] thr;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rxq_fifo_top dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .full    (full),
      .ovf     (ovf),
      .ovf_clr (ovf_clr),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .empty   (empty),
      .count   (count),
      .thr     (thr),
      .af_irq  (af_irq),
      .af_ack  (af_ack)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit w, input logic [7:0] d, input bit r, input bit a, input bit c);
      @(negedge clk);
      wr_en = w; wr_data = d; rd_en = r; af_ack = a; ovf_clr = c;
      @(posedge clk);
      #1;
      wr_en = 0; rd_en = 0; af_ack = 0; ovf_clr = 0;
   endtask

   task automatic push(input logic [7:0] d);
      step(1, d, 0, 0, 0);
   endtask

   task automatic pop_chk(input logic [7:0] exp, input string req);
      chk(req, int'(rd_data), int'(exp));
      step(0, 8'h00, 1, 0, 0);
   endtask

   task automatic drain_ack();
      for (int i = 0; i < 70 && !empty; i++) step(0, 8'h00, 1, 0, 0);
      step(0, 8'h00, 0, 1, 1);
      chk("R3 drained empty", int'(empty), 1);
   endtask

   task automatic t_reset();
      chk("R1 empty", int'(empty), 1);
      chk("R1 full", int'(full), 0);
      chk("R1 count", int'(count), 0);
      chk("R1 af_irq", int'(af_irq), 0);
      chk("R1 ovf", int'(ovf), 0);
   endtask

   task automatic t_order();
      thr = 7'd0;
      for (int i = 0; i < 10; i++) push(8'hA0 + 8'(i));
      chk("R3 count after 10", int'(count), 10);
      chk("R3 not empty", int'(empty), 0);
      for (int i = 0; i < 10; i++) pop_chk(8'hA0 + 8'(i), "R2 order");
      chk("R3 empty after drain", int'(empty), 1);
   endtask

   task automatic t_trip(input int th, input int exp_trip);
      thr = 7'(th);
      step(0, 8'h00, 0, 1, 0);
      for (int i = 1; i <= exp_trip; i++) begin
         push(8'(i));
         chk($sformatf("R6 thr=%0d irq after byte %0d", th, i), int'(af_irq), (i >= exp_trip) ? 1 : 0);
      end
      chk("R3 count at trip", int'(count), exp_trip);
      push(8'h55);
      step(0, 8'h00, 0, 0, 0);
      chk("R8 irq sticky", int'(af_irq), 1);
      step(0, 8'h00, 0, 1, 0);
      chk("R8 ack clears", int'(af_irq), 0);
      push(8'h56);
      chk("R6 no retrigger above level", int'(af_irq), 0);
      drain_ack();
   endtask

   task automatic t_full_ovf();
      thr = 7'd0;
      for (int i = 0; i < 64; i++) push(8'(i * 3));
      chk("R3 full at 64", int'(full), 1);
      chk("R3 count 64", int'(count), 64);
      chk("R7 thr zero no irq", int'(af_irq), 0);
      push(8'hEE);
      chk("R4 ovf set", int'(ovf), 1);
      chk("R4 count held", int'(count), 64);
      step(0, 8'h00, 0, 0, 0);
      chk("R4 ovf sticky", int'(ovf), 1);
      for (int i = 0; i < 64; i++) pop_chk(8'(i * 3), "R4 R2 contents after drop");
      chk("R3 empty", int'(empty), 1);
      chk("R4 ovf before clear", int'(ovf), 1);
      step(0, 8'h00, 0, 0, 1);
      chk("R4 ovf cleared", int'(ovf), 0);
      step(0, 8'h00, 1, 0, 0);
      chk("R5 empty read count", int'(count), 0);
      chk("R5 empty read flag", int'(empty), 1);
      push(8'h3C);
      pop_chk(8'h3C, "R5 pointers intact");
   endtask

   task automatic t_above();
      thr = 7'd65;
      step(0, 8'h00, 0, 1, 0);
      for (int i = 0; i < 64; i++) push(8'(i));
      chk("R10 full", int'(full), 1);
      chk("R10 unreachable level", int'(af_irq), 0);
      drain_ack();
   endtask

   task automatic t_both();
      thr = 7'd4;
      step(0, 8'h00, 0, 1, 0);
      push(8'h01); push(8'h02); push(8'h03);
      step(1, 8'h04, 1, 0, 0);
      chk("R9 count unchanged", int'(count), 3);
      chk("R9 no irq", int'(af_irq), 0);
      push(8'h05);
      chk("R6 push to level", int'(af_irq), 1);
      chk("R6 count 4", int'(count), 4);
      step(0, 8'h00, 0, 1, 0);
      pop_chk(8'h02, "R9 R2 order");
      push(8'h06);
      chk("R6 refire after refill", int'(af_irq), 1);
      step(0, 8'h00, 0, 1, 0);
      pop_chk(8'h03, "R2 order");
      pop_chk(8'h04, "R2 order");
      pop_chk(8'h05, "R2 order");
      pop_chk(8'h06, "R2 order");
      drain_ack();
   endtask

   task automatic t_ack_race();
      thr = 7'd8;
      step(0, 8'h00, 0, 1, 0);
      for (int i = 0; i < 7; i++) push(8'(i));
      chk("R8 below level", int'(af_irq), 0);
      step(1, 8'h77, 0, 1, 0);
      chk("R8 set wins over ack", int'(af_irq), 1);
      drain_ack();
      chk("R8 cleared", int'(af_irq), 0);
   endtask

   initial begin
      rst_n = 0; wr_en = 0; rd_en = 0; af_ack = 0; ovf_clr = 0; wr_data = '0; thr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      t_order();
      t_trip(1, 4);
      t_trip(3, 4);
      t_trip(4, 4);
      t_trip(5, 8);
      t_trip(8, 8);
      t_trip(9, 12);
      t_trip(13, 16);
      t_trip(62, 64);
      t_full_ovf();
      t_above();
      t_both();
      t_ack_race();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(5 * 150000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule